// File: doc/BRIEF.md
# Transmit Descriptor Gather Engine

This block turns a ring of transmit descriptors in host memory into outgoing frames. Software places descriptors in a ring and then writes a kick code to the control input. The engine walks the ring from its saved index, fetching each descriptor over a simple request/acknowledge memory port. For every descriptor that carries the valid flag it reads the fragment bytes one at a time into an internal staging buffer, then rewrites the descriptor's control word to hand it back to software.

A descriptor carrying the last-fragment flag closes the frame. The staged bytes then leave on a byte stream, one byte per cycle, with a marker on the final byte. The walk ends there, and a one-cycle interrupt-set pulse reports that a frame went out. A ring reset command on the same control input rewinds the transmit index and the staging offset, and tells the receive side to rewind its own index.

Top module: `tx_gather_engine`

## Requirements
- R1: While idle, a control write starts a walk only when its data equals the kick code (default 0x01). Any other value, for example 0x03 or 0x81, starts no walk, produces no memory request and no output, and leaves `idle` high.
- R2: Descriptor i occupies 8 bytes at ring_base + 8*i. The word at +4 holds the length minus one in bits [15:0] and the flags in bits [31:16]. Bit 31 is the valid flag and bit 16 is the last-fragment flag. The word at +0 holds the fragment buffer address. A descriptor with bit 31 clear ends the walk; it is not written back and the index does not move past it.
- R3: A valid fragment copies length+1 bytes, starting at its buffer address (byte i of the frame is bits [7:0] of the read data at address buffer+i). The bytes are appended after those already staged, so fragments concatenate across descriptors.
- R4: After a descriptor with the last flag, the staged bytes leave on `out_data` in order, one per cycle, with `out_last` on the final byte. The staging offset then returns to zero and the walk ends, even if further valid descriptors follow.
- R5: Each consumed descriptor has its word at +4 rewritten. Bits 31..25 (valid plus six transmit error flags) are cleared, bits 24..16 are kept, and the length field is increased by 5 modulo 2^16.
- R6: A walk examines at most ring_size_m1+1 descriptors. The index wraps to 0 after ring_size_m1 and persists from one walk to the next.
- R7: `irq_set` pulses for exactly one cycle at the end of a walk that sent a frame, and stays low after a walk that sent none.
- R8: A control write while idle with bit 4 set clears the transmit index and the staging offset, and pulses `rx_index_clr` for one cycle.
- R9: A fragment whose length+1 would take the staging offset past STAGE_BYTES is discarded and pulses `ovf_err`. Its descriptor is still written back and the index still advances; bytes already staged are kept.
- R10: `idle` is high out of reset. It goes low in the cycle after a kick is accepted and returns high when the walk ends. Memory requests appear only while not idle, and a request holds its address and direction until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ring_base | input | ADDR_W | Byte address of descriptor 0 |
| ring_size_m1 | input | IDX_W | Number of descriptors in the ring minus one |
| ctl_wr | input | 1 | Control write strobe |
| ctl_data | input | CTL_W | Control write data (kick code or ring reset bit) |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | 32 | Write data (descriptor write-back) |
| mem_ack | input | 1 | Access completed; read data valid |
| mem_rdata | input | 32 | Read data |
| out_valid | output | 1 | Frame byte valid |
| out_data | output | 8 | Frame byte |
| out_last | output | 1 | Final byte of the frame |
| irq_set | output | 1 | One-cycle pulse: a frame was sent during the walk |
| ovf_err | output | 1 | One-cycle pulse: fragment discarded for staging overflow |
| rx_index_clr | output | 1 | One-cycle pulse: receive index must be cleared |
| idle | output | 1 | High when no walk is in progress |

## Verification
The bench builds the engine with IDX_W of 4, a four-entry ring and STAGE_BYTES of 16. With a four-entry ring, index wrap and the cap on descriptors per walk each take only a few kicks to reach. With a 16-byte staging buffer, a walk that exactly fills the buffer is within reach, and so is one that overflows it with two ten-byte fragments. A behavioural model holds its own copy of memory, replays every kick and reset, and predicts the byte stream, the pulses and every written-back descriptor. The model's byte queue is compared with the stream on every clock.

// File: rtl/gx_pkg.sv
package gx_pkg;
   typedef enum logic [2:0] {
      GX_IDLE,
      GX_RD_CTL,
      GX_RD_BUF,
      GX_COPY,
      GX_WB,
      GX_SEND,
      GX_FIN
   } gx_state_e;

   // positions inside the upper half (flags) of the control word
   localparam int unsigned FLG_VALID = 15;
   localparam int unsigned FLG_LAST  = 0;
   // valid plus six transmit error flags, cleared on write-back
   localparam logic [15:0] FLG_CLEAR_MASK = 16'hFE00;
   localparam logic [15:0] WB_LEN_BUMP    = 16'd5;
endpackage

// File: rtl/gx_ring_walker.sv
module gx_ring_walker #(
   parameter int unsigned IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             start,
   input  logic             adv,
   input  logic [IDX_W-1:0] size_m1,
   output logic [IDX_W-1:0] idx,
   output logic             final_slot
);
   localparam int unsigned EXT_W = IDX_W + 1;

   logic [IDX_W-1:0] size_q;
   logic [IDX_W-1:0] cnt_q;
   logic [EXT_W-1:0] size_ext;
   logic [EXT_W-1:0] idx_mod;

   generate
      if (IDX_W < 1 || IDX_W > 16) begin : g_bad_idx
         $error("gx_ring_walker: IDX_W out of range");
      end
   endgenerate

   assign size_ext   = {1'b0, size_m1} + EXT_W'(1);
   assign idx_mod    = {1'b0, idx} % size_ext;
   assign final_slot = (cnt_q == size_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx    <= '0;
         cnt_q  <= '0;
         size_q <= '0;
      end else if (clr) begin
         idx   <= '0;
         cnt_q <= '0;
      end else if (start) begin
         idx    <= idx_mod[IDX_W-1:0];
         cnt_q  <= '0;
         size_q <= size_m1;
      end else if (adv) begin
         idx   <= (idx == size_q) ? '0 : idx + IDX_W'(1);
         cnt_q <= cnt_q + IDX_W'(1);
      end
   end
endmodule

// File: rtl/gx_stage_buf.sv
module gx_stage_buf #(
   parameter int unsigned BYTES = 64,
   localparam int unsigned OFF_W = $clog2(BYTES + 1),
   localparam int unsigned PTR_W = $clog2(BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr,
   input  logic [7:0]       wdata,
   input  logic [PTR_W-1:0] rd_ptr,
   output logic [OFF_W-1:0] off,
   output logic [7:0]       rd_data
);
   logic [BYTES*8-1:0] flat;

   generate
      if (BYTES < 2 || BYTES > 1024) begin : g_bad_bytes
         $error("gx_stage_buf: BYTES out of range");
      end
      for (genvar g = 0; g < BYTES; g++) begin : g_cell
         logic [7:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (wr && off == OFF_W'(g))
               q <= wdata;
         end
         assign flat[g*8 +: 8] = q;
      end
   endgenerate

   assign rd_data = flat[rd_ptr*8 +: 8];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         off <= '0;
      else if (clr)
         off <= '0;
      else if (wr)
         off <= off + OFF_W'(1);
   end
endmodule

// File: rtl/tx_gather_engine.sv
module tx_gather_engine #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned IDX_W       = 8,
   parameter int unsigned STAGE_BYTES = 64,
   parameter int unsigned CTL_W       = 8,
   parameter logic [7:0]  KICK_CODE   = 8'h01,
   parameter int unsigned RST_BIT     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] ring_base,
   input  logic [IDX_W-1:0]  ring_size_m1,
   input  logic              ctl_wr,
   input  logic [CTL_W-1:0]  ctl_data,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata,
   output logic              out_valid,
   output logic [7:0]        out_data,
   output logic              out_last,
   output logic              irq_set,
   output logic              ovf_err,
   output logic              rx_index_clr,
   output logic              idle
);
   import gx_pkg::*;

   localparam int unsigned OFF_W = $clog2(STAGE_BYTES + 1);
   localparam int unsigned PTR_W = $clog2(STAGE_BYTES);
   localparam int unsigned SUM_W = 18;

   generate
      if (ADDR_W < IDX_W + 3) begin : g_bad_addr
         $error("tx_gather_engine: ADDR_W too small for ring");
      end
      if (RST_BIT >= CTL_W || CTL_W > 8) begin : g_bad_ctl
         $error("tx_gather_engine: control field layout invalid");
      end
      if (KICK_CODE[RST_BIT]) begin : g_bad_kick
         $error("tx_gather_engine: kick code overlaps reset bit");
      end
   endgenerate

   gx_state_e         state_q;
   logic [15:0]       flags_q;
   logic [15:0]       len_q;
   logic [ADDR_W-1:0] buf_addr_q;
   logic [16:0]       remain_q;
   logic [PTR_W-1:0]  send_ptr_q;
   logic              sent_q;

   logic [IDX_W-1:0]  idx;
   logic              final_slot;
   logic [OFF_W-1:0]  off;
   logic [7:0]        stage_rd;
   logic [ADDR_W-1:0] desc_addr;
   logic [SUM_W-1:0]  need_end;
   logic              frag_fits;
   logic              kick_acc;
   logic              stage_clr;
   logic              stage_wr;
   logic              walk_adv;

   assign idle         = (state_q == GX_IDLE);
   assign kick_acc     = idle && ctl_wr && (ctl_data == CTL_W'(KICK_CODE));
   assign rx_index_clr = idle && ctl_wr && ctl_data[RST_BIT];
   assign desc_addr    = ring_base + ADDR_W'({idx, 3'b000});
   assign need_end     = SUM_W'(off) + SUM_W'(len_q) + SUM_W'(1);
   assign frag_fits    = (need_end <= SUM_W'(STAGE_BYTES));

   assign mem_req = (state_q == GX_RD_CTL) || (state_q == GX_RD_BUF) ||
                    (state_q == GX_COPY)   || (state_q == GX_WB);
   assign mem_we  = (state_q == GX_WB);
   always_comb begin
      case (state_q)
         GX_RD_CTL, GX_WB: mem_addr = desc_addr + ADDR_W'(4);
         GX_COPY:          mem_addr = buf_addr_q;
         default:          mem_addr = desc_addr;
      endcase
   end
   assign mem_wdata = {flags_q & ~FLG_CLEAR_MASK, len_q + WB_LEN_BUMP};

   assign out_valid = (state_q == GX_SEND);
   assign out_data  = stage_rd;
   assign out_last  = out_valid && ((OFF_W'(send_ptr_q) + OFF_W'(1)) == off);
   assign irq_set   = (state_q == GX_FIN) && sent_q;
   assign ovf_err   = (state_q == GX_RD_BUF) && mem_ack && !frag_fits;

   assign stage_wr  = (state_q == GX_COPY) && mem_ack;
   assign stage_clr = rx_index_clr || out_last;
   assign walk_adv  = (state_q == GX_WB) && mem_ack;

   gx_ring_walker #(.IDX_W(IDX_W)) u_walker (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (rx_index_clr),
      .start      (kick_acc),
      .adv        (walk_adv),
      .size_m1    (ring_size_m1),
      .idx        (idx),
      .final_slot (final_slot)
   );

   gx_stage_buf #(.BYTES(STAGE_BYTES)) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (stage_clr),
      .wr      (stage_wr),
      .wdata   (mem_rdata[7:0]),
      .rd_ptr  (send_ptr_q),
      .off     (off),
      .rd_data (stage_rd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= GX_IDLE;
         flags_q    <= '0;
         len_q      <= '0;
         buf_addr_q <= '0;
         remain_q   <= '0;
         send_ptr_q <= '0;
         sent_q     <= 1'b0;
      end else begin
         case (state_q)
            GX_IDLE: begin
               if (kick_acc) begin
                  sent_q  <= 1'b0;
                  state_q <= GX_RD_CTL;
               end
            end
            GX_RD_CTL: begin
               if (mem_ack) begin
                  flags_q <= mem_rdata[31:16];
                  len_q   <= mem_rdata[15:0];
                  state_q <= mem_rdata[16 + FLG_VALID] ? GX_RD_BUF : GX_FIN;
               end
            end
            GX_RD_BUF: begin
               if (mem_ack) begin
                  buf_addr_q <= mem_rdata[ADDR_W-1:0];
                  remain_q   <= {1'b0, len_q} + 17'd1;
                  state_q    <= frag_fits ? GX_COPY : GX_WB;
               end
            end
            GX_COPY: begin
               if (mem_ack) begin
                  buf_addr_q <= buf_addr_q + ADDR_W'(1);
                  remain_q   <= remain_q - 17'd1;
                  if (remain_q == 17'd1)
                     state_q <= GX_WB;
               end
            end
            GX_WB: begin
               if (mem_ack) begin
                  send_ptr_q <= '0;
                  if (flags_q[FLG_LAST])
                     state_q <= (off != '0) ? GX_SEND : GX_FIN;
                  else if (final_slot)
                     state_q <= GX_FIN;
                  else
                     state_q <= GX_RD_CTL;
               end
            end
            GX_SEND: begin
               send_ptr_q <= send_ptr_q + PTR_W'(1);
               if (out_last) begin
                  sent_q  <= 1'b1;
                  state_q <= GX_FIN;
               end
            end
            default: state_q <= GX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/gx_checker.sv
module gx_checker #(
   parameter int unsigned ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              idle,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_ack,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              out_valid,
   input logic              out_last,
   input logic              irq_set,
   input logic              ovf_err
);
   // R10
   busy_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !idle);

   // R10
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R4
   last_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);

   // R4
   stream_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (!idle && !mem_req));

   // R7
   irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_set |=> (!irq_set && idle));

   // R9
   ovf_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_err |-> (!idle && !out_valid));
endmodule

bind tx_gather_engine gx_checker #(.ADDR_W(ADDR_W)) u_gx_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .idle      (idle),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_ack   (mem_ack),
   .mem_addr  (mem_addr),
   .out_valid (out_valid),
   .out_last  (out_last),
   .irq_set   (irq_set),
   .ovf_err   (ovf_err)
);

// File: tb/tx_gather_engine_bench.sv
module tx_gather_engine_bench;
   localparam int AW   = 32;
   localparam int IW   = 4;
   localparam int SB   = 16;
   localparam int SIZE = 4;
   localparam int BASE = 'h100;
   localparam logic [15:0] F_VALID = 16'h8000;
   localparam logic [15:0] F_LAST  = 16'h0001;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] ring_base = AW'(BASE);
   logic [IW-1:0] ring_size_m1 = IW'(SIZE - 1);
   logic          ctl_wr = 1'b0;
   logic [7:0]    ctl_data = '0;
   logic          mem_req, mem_we, mem_ack;
   logic [AW-1:0] mem_addr;
   logic [31:0]   mem_wdata, mem_rdata;
   logic          out_valid, out_last, irq_set, ovf_err, rx_index_clr, idle;
   logic [7:0]    out_data;

   always #5 clk = ~clk;

   tx_gather_engine #(.ADDR_W(AW), .IDX_W(IW), .STAGE_BYTES(SB)) u_tx_gather_engine (
      .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .ring_size_m1(ring_size_m1),
      .ctl_wr(ctl_wr), .ctl_data(ctl_data), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .irq_set(irq_set),
      .ovf_err(ovf_err), .rx_index_clr(rx_index_clr), .idle(idle)
   );

   logic [7:0] mem [0:1023];
   logic [7:0] sh  [0:1023];
   logic [7:0] exp_b [$];
   bit         exp_l [$];
   int nchk = 0, nerr = 0;
   int got_irq = 0, got_ovf = 0, got_rx = 0;
   int exp_irq = 0, exp_ovf = 0, exp_rx = 0;
   int m_idx = 0, m_off = 0;
   logic [7:0] m_stage [$];
   string cur_req = "R4";
   bit timeout = 0;

   task automatic chk(bit ok, string req, string what, int act, int expv);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   function automatic logic [31:0] sh_rd32(int a);
      return {sh[(a+3)&1023], sh[(a+2)&1023], sh[(a+1)&1023], sh[a&1023]};
   endfunction
   function automatic logic [31:0] mem_rd32(int a);
      return {mem[(a+3)&1023], mem[(a+2)&1023], mem[(a+1)&1023], mem[a&1023]};
   endfunction

   task automatic put32(int a, logic [31:0] v);
      for (int k = 0; k < 4; k++) begin
         mem[(a+k)&1023] = v[k*8 +: 8];
         sh[(a+k)&1023]  = v[k*8 +: 8];
      end
   endtask

   task automatic set_desc(int i, int len_m1, logic [15:0] flg, logic [7:0] seed);
      int ba;
      ba = 'h200 + i * 'h40;
      put32(BASE + i*8, 32'(ba));
      put32(BASE + i*8 + 4, {flg, 16'(len_m1)});
      for (int k = 0; k < 'h40; k++) begin
         mem[ba+k] = seed + 8'(k*3);
         sh[ba+k]  = seed + 8'(k*3);
      end
   endtask

   task automatic model_kick();
      int idx, da, ba, ln;
      logic [31:0] w1;
      bit last, sent;
      idx = m_idx % SIZE;
      sent = 0;
      for (int n = 0; n < SIZE; n++) begin
         da = BASE + idx*8;
         w1 = sh_rd32(da + 4);
         if (!w1[31]) break;
         ln = int'(w1[15:0]);
         ba = int'(sh_rd32(da));
         last = w1[16];
         if (m_off + ln + 1 > SB) exp_ovf++;
         else begin
            for (int k = 0; k <= ln; k++) m_stage.push_back(sh[(ba+k)&1023]);
            m_off += ln + 1;
         end
         w1 = {w1[31:16] & 16'h01FF, w1[15:0] + 16'd5};
         for (int k = 0; k < 4; k++) sh[(da+4+k)&1023] = w1[k*8 +: 8];
         idx = (idx == SIZE-1) ? 0 : idx + 1;
         if (last) begin
            if (m_off > 0) begin
               for (int k = 0; k < m_stage.size(); k++) begin
                  exp_b.push_back(m_stage[k]);
                  exp_l.push_back(k == m_stage.size() - 1);
               end
               sent = 1;
            end
            m_stage.delete();
            m_off = 0;
            break;
         end
      end
      m_idx = idx;
      if (sent) exp_irq++;
   endtask

   task automatic do_ctl(logic [7:0] v, string req);
      bit kick;
      cur_req = req;
      kick = (v == 8'h01);
      @(negedge clk);
      ctl_wr = 1'b1;
      ctl_data = v;
      if (v[4]) begin
         m_idx = 0; m_off = 0; m_stage.delete(); exp_rx++;
      end
      if (kick) model_kick();
      @(negedge clk);
      ctl_wr = 1'b0;
      if (kick) chk(idle == 1'b0, "R10", "idle low after kick", int'(idle), 0);
      else      chk(idle == 1'b1 && !mem_req, "R1", "no walk on non-kick write", int'(idle), 1);
      while (!idle) @(negedge clk);
      @(negedge clk);
      chk(exp_b.size() == 0, req, "frame bytes outstanding", exp_b.size(), 0);
      chk(got_irq == exp_irq, "R7", "interrupt pulses", got_irq, exp_irq);
      chk(got_ovf == exp_ovf, "R9", "overflow pulses", got_ovf, exp_ovf);
      chk(got_rx == exp_rx, "R8", "rx index clear pulses", got_rx, exp_rx);
      for (int a = BASE; a < BASE + 8*SIZE; a += 4)
         chk(mem_rd32(a) == sh_rd32(a), "R5", $sformatf("descriptor word @%0h", a),
             int'(mem_rd32(a)), int'(sh_rd32(a)));
   endtask

   task automatic main_seq();
      repeat (3) @(negedge clk);
      chk(idle == 1'b1, "R10", "idle in reset", int'(idle), 1);
      chk(!out_valid && !mem_req && !irq_set, "R10", "outputs quiet in reset", int'(out_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 R3 R4 R5: single four-byte frame
      set_desc(0, 3, F_VALID | F_LAST | 16'h7E00, 8'h10);
      set_desc(1, 0, 16'h0000, 8'h20);
      set_desc(2, 0, 16'h0000, 8'h30);
      set_desc(3, 0, 16'h0000, 8'h40);
      do_ctl(8'h01, "R3");
      // R1: values other than the kick code
      do_ctl(8'h03, "R1");
      do_ctl(8'h81, "R1");
      // R3 R4: concatenated fragments, walk stops after last
      set_desc(1, 2, F_VALID, 8'h50);
      set_desc(2, 1, F_VALID | F_LAST, 8'h60);
      set_desc(3, 0, F_VALID | F_LAST, 8'h70);
      do_ctl(8'h01, "R4");
      chk(mem_rd32(BASE + 28) >> 31 == 1, "R4", "descriptor after last untouched",
          int'(mem_rd32(BASE + 28) >> 31), 1);
      do_ctl(8'h01, "R4");
      // R2: index wrapped to 0, descriptor 0 no longer valid
      do_ctl(8'h01, "R2");
      // R6: wrapped index reaches descriptor 0
      set_desc(0, 5, F_VALID | F_LAST, 8'h80);
      do_ctl(8'h01, "R6");
      // R8: ring reset then a full walk with no last flag
      do_ctl(8'h10, "R8");
      for (int i = 0; i < SIZE; i++) set_desc(i, 3, F_VALID, 8'(8'h90 + i*16));
      do_ctl(8'h01, "R6");
      do_ctl(8'h10, "R8");
      set_desc(0, 1, F_VALID | F_LAST, 8'hA0);
      do_ctl(8'h01, "R8");
      // R9: second ten-byte fragment does not fit
      set_desc(1, 9, F_VALID, 8'hB0);
      set_desc(2, 9, F_VALID | F_LAST, 8'hC0);
      do_ctl(8'h01, "R9");
   endtask

   initial begin
      for (int a = 0; a < 1024; a++) begin
         mem[a] = '0;
         sh[a]  = '0;
      end
      mem_ack = 1'b0;
      mem_rdata = '0;
      fork
         forever begin
            @(negedge clk);
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req) begin
               mem_ack = 1'b1;
               if (mem_we)
                  for (int k = 0; k < 4; k++) mem[(int'(mem_addr)+k)&1023] = mem_wdata[k*8 +: 8];
               mem_rdata = mem_rd32(int'(mem_addr));
            end
            if (rst_n) begin
               if (irq_set) got_irq++;
               if (ovf_err) got_ovf++;
               if (rx_index_clr) got_rx++;
               if (out_valid) begin
                  if (exp_b.size() == 0)
                     chk(0, cur_req, "unexpected frame byte", int'(out_data), 0);
                  else begin
                     logic [7:0] eb;
                     bit el;
                     eb = exp_b.pop_front();
                     el = exp_l.pop_front();
                     chk(out_data == eb, cur_req, "frame byte", int'(out_data), int'(eb));
                     chk(out_last == el, "R4", "end-of-frame marker", int'(out_last), int'(el));
                  end
               end
            end
         end
         begin
            repeat (50000) @(posedge clk);
            timeout = 1;
         end
         main_seq();
      join_any
      if (timeout) chk(0, "R10", "watchdog expired", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule